// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a serial-bus slave that lets a system controller read and write a bank of eleven 8-bit configuration bytes. It answers to the 7-bit device address 0x69, which is 0xD2 on the wire for writes and 0xD3 for reads. It supports four transfers:

- a single indexed byte write;
- a single indexed byte read;
- a sequential block write starting at byte 0;
- a sequential block read starting at byte 0.

Bit 7 of the command byte selects between indexed and block access.

SCL and SDA are sampled by a fast system clock through two-flop synchronizers. All protocol decisions are taken on the synchronized edges. The block never drives SDA high. It only asserts `sda_oe` to pull the line low, and the pad logic outside this block performs the open-drain drive.

The stored bytes appear in parallel on `cfg_out` for the rest of the chip. Two of the bytes are not fully stored:

- The identification byte always shows `id_in`.
- The three low bits of byte 6 always show the latched strap inputs.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, bytes 0 to 10 of `cfg_out` read as follows:
  - byte 0 = 0xFF
  - byte 1 = 0xFE
  - byte 2 = 0xFF
  - byte 3 = 0x00
  - byte 4 = 0x07
  - byte 5 = 0x00
  - byte 6 = {0b00011, `strap_in`}
  - byte 7 = `id_in`
  - byte 8 = 0x44
  - byte 9 = 0x0E
  - byte 10 = 0x00
- R2: The slave acknowledges a first byte whose upper seven bits are 0x69, and acknowledges every later byte it receives in the same transfer. For any other address it never pulls SDA low, and the following bytes have no effect until the next START.
- R3: In a byte write, the command byte has bit 7 = 1 and the offset in bits 6:0. The following data byte is stored at that offset.
- R4: In a byte read, the sequence is: address+W, command with bit 7 = 1, repeated START, address+R. The slave then returns the byte at that offset, most significant bit first.
- R5: In a block write, the sequence is: command 0x00, a byte-count byte (its value is not used), then data bytes stored at offsets 0, 1, 2 in order. A STOP after any whole byte leaves the higher offsets unchanged.
- R6: In a block read, the sequence is: command 0x00, repeated START, address+R. The slave first returns the value 11, then bytes 0, 1, 2 and onward. After the controller's NACK the slave releases SDA and stays released.
- R7: Writes to offset 7, to bits 2:0 of offset 6, or to any offset of 11 or above are acknowledged but change nothing visible. Reads of offsets 11 and above return 0x00.
- R8: `sda_oe` asserts only while SCL is low. The only exception is that START and STOP release it at once.
- R9: A START in the middle of a byte discards the partial byte, and the next byte is taken as an address. A STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, many times faster than SCL |
| rst_n | input | 1 | Active-low reset, loads register defaults |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_in | input | 3 | Latched strap values shown in bits 2:0 of byte 6 |
| id_in | input | 8 | Identification value shown as byte 7 |
| cfg_out | output | 88 | Byte i of the register view in bits 8i+7:8i |

## Verification
The bench runs each kind of transfer against a byte model of the register view and looks for framing slips:

- **Off-by-one bit counter.** A design with this fault acknowledges on the wrong bit or stores a shifted byte.
- **Block read without the count.** A design that skips the leading count byte returns every byte one position early.
- **Leftover address decode.** A design that keeps decoding after a foreign address pulls SDA low or writes a register.
- **Lost offset.** The bench interrupts a byte with a repeated START and then checks that the next write still lands at the correct offset.

Writes to the identification byte, to the strap bits and above the last offset are checked through `cfg_out` and through readback. A design that drops the read-only mask shows the written value in place of the strap or identification value.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 11,
  parameter int ID_IDX = 7,
  parameter int STRAP_IDX = 6,
  parameter int STRAP_W = 3,
  parameter logic [NREG*8-1:0] DEFAULTS = 88'h00_0E_44_08_18_00_07_00_FF_FE_FF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                sda_oe,
  input  logic [STRAP_W-1:0]  strap_in,
  input  logic [7:0]          id_in,
  output logic [NREG*8-1:0]   cfg_out
);
  localparam int IW = $clog2(NREG);
  localparam logic [7:0] COUNT_BYTE = 8'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD} st_t;

  st_t        st;
  logic [2:0] scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic [6:0] ptr;
  logic       cnt_first, nack;
  logic [7:0] regs [NREG];
  logic [7:0] view [NREG];

  wire scl_s = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_d = sda_p[2];
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end

  always_comb begin
    for (int i = 0; i < NREG; i++) view[i] = regs[i];
    view[ID_IDX] = id_in;
    view[STRAP_IDX][STRAP_W-1:0] = strap_in;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_out[g*8 +: 8] = view[g];
  end

  wire        ptr_ok  = int'(ptr) < NREG;
  wire        ptr_wr  = ptr_ok && (int'(ptr) != ID_IDX);
  wire [7:0]  rd_byte = ptr_ok ? view[ptr[IW-1:0]] : 8'h00;
  wire [7:0]  nxt     = cnt_first ? COUNT_BYTE : rd_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= 4'd0;
      sh <= 8'h00;
      tx <= 8'h00;
      ptr <= 7'd0;
      cnt_first <= 1'b0;
      nack <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= DEFAULTS[i*8 +: 8];
    end else if (start_c) begin
      st <= S_ADDR;
      cnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE;
      cnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (cnt < 4'd8) sh <= {sh[6:0], sda_s};
        if (cnt == 4'd8) nack <= sda_s;
        cnt <= cnt + 4'd1;
      end
      if (scl_fall) begin
        if (cnt == 4'd8) begin
          case (st)
            S_ADDR:
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                st <= sh[0] ? S_RD : S_CMD;
              end else st <= S_IDLE;
            S_CMD: begin
              sda_oe <= 1'b1;
              ptr <= sh[7] ? sh[6:0] : 7'd0;
              cnt_first <= ~sh[7];
              st <= sh[7] ? S_WR : S_CNT;
            end
            S_CNT: begin
              sda_oe <= 1'b1;
              st <= S_WR;
            end
            S_WR: begin
              sda_oe <= 1'b1;
              if (ptr_wr) regs[ptr[IW-1:0]] <= sh;
              if (ptr != 7'h7f) ptr <= ptr + 7'd1;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (cnt == 4'd9) begin
          cnt <= 4'd0;
          if (st == S_RD && !nack) begin
            tx <= nxt;
            sda_oe <= ~nxt[7];
            if (cnt_first) cnt_first <= 1'b0;
            else if (ptr != 7'h7f) ptr <= ptr + 7'd1;
          end else begin
            sda_oe <= 1'b0;
            if (st == S_RD) st <= S_IDLE;
          end
        end else if (st == S_RD && cnt != 4'd0) begin
          sda_oe <= ~tx[3'(4'd7 - cnt)];
        end
      end
    end

  p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  p_ack_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && st != S_RD) |-> (cnt == 4'd8));

  p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  p_write_at_byte_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs[0]) |-> ($past(cnt) == 4'd8 && $past(st) == S_WR));

  p_frame_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd9);
endmodule

// File: tb/smb_cfg_slave_test.sv
module smb_cfg_slave_test;
  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic sda_oe;
  logic [2:0] strap = 3'b101;
  logic [7:0] id = 8'h08;
  logic [87:0] cfg;
  wire sda_bus = sda_m & ~sda_oe;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_m [11];

  always #10 clk = ~clk;

  smb_cfg_slave uut (.clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .strap_in(strap), .id_in(id), .cfg_out(cfg));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, expv);
    end
  endtask

  task automatic wq;
    repeat (8) @(posedge clk);
    #2;
  endtask

  task automatic bstart;
    sda_m = 1; wq; scl = 1; wq; sda_m = 0; wq; scl = 0; wq;
  endtask

  task automatic bstop;
    sda_m = 0; wq; scl = 1; wq; sda_m = 1; wq;
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq; scl = 1; wq; wq; scl = 0; wq;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1; wq; scl = 1; wq; b = sda_bus; wq; scl = 0; wq;
  endtask

  task automatic send(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv(input logic last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(last);
  endtask

  task automatic chk_all(input string tag);
    for (int i = 0; i < 11; i++) chk(tag, cfg[i*8 +: 8], exp_m[i]);
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] d, input string tag);
    logic a;
    bstart;
    send(8'hD2, a); chk({tag, " addr ack"}, {7'd0, a}, 8'd1);
    send({1'b1, off}, a); chk({tag, " cmd ack"}, {7'd0, a}, 8'd1);
    send(d, a); chk({tag, " data ack"}, {7'd0, a}, 8'd1);
    bstop;
  endtask

  task automatic byte_read(input logic [6:0] off, output logic [7:0] d);
    logic a;
    bstart;
    send(8'hD2, a);
    send({1'b1, off}, a);
    bstart;
    send(8'hD3, a); chk("R4 read addr ack", {7'd0, a}, 8'd1);
    recv(1'b1, d);
    bstop;
  endtask

  task automatic t_reset;
    chk_all("R1 reset value");
    chk("R1 idle sda", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic t_byte_rw;
    logic [7:0] d;
    byte_write(7'd3, 8'h5A, "R3");
    exp_m[3] = 8'h5A;
    chk_all("R3 after byte write");
    byte_read(7'd3, d); chk("R4 read offset 3", d, 8'h5A);
    byte_read(7'd8, d); chk("R4 read offset 8", d, 8'h44);
    byte_read(7'd7, d); chk("R4 read id byte", d, 8'h08);
  endtask

  task automatic t_wrong_addr;
    logic a;
    bstart;
    send(8'hA0, a); chk("R2 foreign addr no ack", {7'd0, a}, 8'd0);
    send(8'h83, a); chk("R2 foreign cmd no ack", {7'd0, a}, 8'd0);
    send(8'h77, a); chk("R2 foreign data no ack", {7'd0, a}, 8'd0);
    bstop;
    chk_all("R2 no change after foreign addr");
  endtask

  task automatic t_block_write;
    logic a;
    bstart;
    send(8'hD2, a); chk("R5 addr ack", {7'd0, a}, 8'd1);
    send(8'h00, a); chk("R5 cmd ack", {7'd0, a}, 8'd1);
    send(8'h03, a); chk("R5 count ack", {7'd0, a}, 8'd1);
    send(8'h11, a); chk("R5 data0 ack", {7'd0, a}, 8'd1);
    send(8'h22, a); chk("R5 data1 ack", {7'd0, a}, 8'd1);
    send(8'h33, a); chk("R5 data2 ack", {7'd0, a}, 8'd1);
    bstop;
    exp_m[0] = 8'h11; exp_m[1] = 8'h22; exp_m[2] = 8'h33;
    chk_all("R5 after block write");
  endtask

  task automatic t_block_read;
    logic a;
    logic [7:0] d;
    bstart;
    send(8'hD2, a);
    send(8'h00, a);
    bstart;
    send(8'hD3, a); chk("R6 read addr ack", {7'd0, a}, 8'd1);
    recv(1'b0, d); chk("R6 byte count", d, 8'd11);
    for (int i = 0; i < 11; i++) begin
      recv(i == 10, d);
      chk("R6 block data", d, exp_m[i]);
    end
    chk("R6 released after nack", {7'd0, sda_oe}, 8'd0);
    bstop;
    chk("R6 released after stop", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic t_read_only;
    logic [7:0] d;
    byte_write(7'd7, 8'hAA, "R7 id");
    byte_write(7'd6, 8'hE0, "R7 strap");
    byte_write(7'd12, 8'h55, "R7 beyond");
    exp_m[6] = 8'hE5;
    chk_all("R7 after read-only writes");
    byte_read(7'd12, d); chk("R7 read beyond end", d, 8'h00);
    byte_read(7'd7, d); chk("R7 id unchanged", d, 8'h08);
  endtask

  task automatic t_restart;
    bstart;
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    byte_write(7'd5, 8'hC3, "R9");
    exp_m[5] = 8'hC3;
    chk_all("R9 write after interrupted byte");
    chk("R9 idle after stop", {7'd0, sda_oe}, 8'd0);
  endtask

  initial begin
    exp_m[0] = 8'hFF; exp_m[1] = 8'hFE; exp_m[2] = 8'hFF; exp_m[3] = 8'h00;
    exp_m[4] = 8'h07; exp_m[5] = 8'h00; exp_m[6] = 8'h1D; exp_m[7] = 8'h08;
    exp_m[8] = 8'h44; exp_m[9] = 8'h0E; exp_m[10] = 8'h00;
    repeat (5) @(posedge clk);
    #2 rst_n = 1;
    wq;
    t_reset;
    t_byte_rw;
    t_wrong_addr;
    t_block_write;
    t_block_read;
    t_read_only;
    t_restart;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule